// File: doc/BRIEF.md
# Interrupt and Exception Sequencer

This unit sits beside the pipeline of a small 16-bit processor. It decides which change of flow the core takes at each instruction boundary and carries it out. It handles five kinds of event:

- hardware reset;
- a fast external request;
- a normal external request;
- single-step trace;
- software interrupt.

It also handles the three matching return operations. The core reports each completed instruction on `boundary_i`, together with the following PC. It also reports whether that instruction was a software interrupt or a return. The unit answers in one of two ways. Software interrupts and returns get a jump on the same cycle. Vectored events start a vector fetch from program memory, which the core must honour by stalling.

The control is a four-state machine:

| State | Meaning |
|-------|---------|
| BOOT | Held in reset |
| IDLE | Waits for a boundary |
| FETCH | Drives the vector read |
| LOAD | Forms the 22-bit target from the returned word |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| BOOT | FETCH | First clock after reset release |
| IDLE | FETCH | A vectored event (trace, fast or normal) wins at a boundary |
| IDLE | IDLE | No event, a return, or a software interrupt |
| FETCH | LOAD | Always |
| LOAD | IDLE | Always |

The memory returns read data one cycle after `vec_rd_o`.

Status register (8 bits) encoding:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | IE | Interrupt enable |
| 1 | FE | Fast-request enable |
| 2 | TE | Trace enable |
| 7 | PM | Privileged mode |

Bits 3 to 6 are plain flags. The vector locations are 0 for reset, 2 for fast, 4 for normal and 6 for trace.

Top module: `intr_seq`

## Requirements
- R1: After reset is released the unit reads vector location 0. The next cycle it jumps to six zero bits above the 16-bit word read. `sr_o` is 8'h80 from reset onward.
- R2: At a boundary the winner is chosen in this order: trace, then fast, then software interrupt, then normal. Losers are not taken, and pending requests stay pending.
- R3: A taken fast request reads location 2 and jumps to the zero-extended word. It saves the return PC and the status into the fast bank. It sets PM, clears FE, IE and TE, and keeps all other bits.
- R4: A taken normal request reads location 4. It saves into the normal bank, sets PM and clears IE and TE. FE is left unchanged.
- R5: While TE is 1, every boundary that carries no return takes a trace event. The event reads location 6, saves into the normal bank, sets PM and clears IE and TE.
- R6: A legal software interrupt (number 2 to 63) jumps in the same cycle to number×4. It writes `next_pc_i` to general register 14, saves the status into the software shadow, sets PM and clears IE and TE.
- R7: A software interrupt numbered 0 or 1 pulses `illegal_o`. It makes no jump, no register 14 write and no status change.
- R8: A return is coded on `ret_op_i` as 1 for fast, 2 for normal and 3 for software. It jumps in the same cycle to the saved PC (register 14 for software) and restores the status from its own shadow. No event is taken at that boundary.
- R9: A fast request is taken only while FE is 1, and a normal request only while IE is 1. A falling edge seen while disabled stays pending until it is taken.
- R10: The request pins pass through a two-flop synchronizer. A request that falls just before edge k is first taken by a boundary at edge k+3. One falling edge gives exactly one event, however long the pin stays low.
- R11: `stall_o` is high in every state except IDLE. While stalled, boundaries, software interrupts and returns are ignored.
- R12: When no event or return is taken, `sr_we_i` loads `sr_wdata_i` into the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the reset jump |
| fast_req_n | input | 1 | Fast request, active on falling edge, asynchronous |
| norm_req_n | input | 1 | Normal request, active on falling edge, asynchronous |
| boundary_i | input | 1 | An instruction completes this cycle |
| next_pc_i | input | 22 | Return address for the completing instruction |
| soft_i | input | 1 | Completing instruction is a software interrupt |
| soft_num_i | input | 6 | Software interrupt number |
| ret_op_i | input | 2 | Return kind: 0 none, 1 fast, 2 normal, 3 software |
| gr14_i | input | 22 | Current value of general register 14 |
| sr_we_i | input | 1 | Datapath write of the status register |
| sr_wdata_i | input | 8 | Status write data |
| vec_rd_o | output | 1 | Vector read strobe |
| vec_addr_o | output | 22 | Vector read address |
| vec_rdata_i | input | 16 | Vector word, valid one cycle after the strobe |
| jump_o | output | 1 | Redirect the fetch this cycle |
| jump_addr_o | output | 22 | Redirect target |
| gr14_we_o | output | 1 | Write general register 14 |
| gr14_wdata_o | output | 22 | Data for general register 14 |
| illegal_o | output | 1 | Prohibited software interrupt number |
| stall_o | output | 1 | Hold the pipeline |
| sr_o | output | 8 | Status register |

## Verification
All 64 software interrupt numbers are swept, each with different flag bits. This separates the two illegal numbers from the legal ones and checks the ×4 target and the register 14 write for each. For the fast and normal requests, 16 status patterns each are taken and then returned. This tells the FE-clearing fast mask apart from the FE-keeping normal mask, and shows that every bank restores exactly what it saved. Requests are also raised several at a time with a software interrupt and TE set, which exposes the priority order. A request held low across disabled boundaries, and a boundary on each cycle after a pin falls, separate pending retention and synchronizer latency from a re-trigger on the level.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    // status register bit positions
    localparam int SR_IE = 0;
    localparam int SR_FE = 1;
    localparam int SR_TE = 2;
    localparam int SR_PM = 7;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RESET,
        EV_TRACE,
        EV_FAST,
        EV_SOFT,
        EV_NORM
    } event_e;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_FAST = 2'd1,
        RET_NORM = 2'd2,
        RET_SOFT = 2'd3
    } ret_e;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_FETCH,
        ST_LOAD
    } state_e;

    // low bits of the vector location for a vectored event
    function automatic logic [3:0] vec_off(input event_e ev);
        unique case (ev)
            EV_FAST:  vec_off = 4'd2;
            EV_NORM:  vec_off = 4'd4;
            EV_TRACE: vec_off = 4'd6;
            default:  vec_off = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/intr_edge_sync.sv
module intr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_seq_pkg::*;
(
    input  logic   trace_ok,
    input  logic   fast_ok,
    input  logic   soft_ok,
    input  logic   norm_ok,
    output event_e win_o
);
    always_comb begin
        if (trace_ok)      win_o = EV_TRACE;
        else if (fast_ok)  win_o = EV_FAST;
        else if (soft_ok)  win_o = EV_SOFT;
        else if (norm_ok)  win_o = EV_NORM;
        else               win_o = EV_NONE;
    end
endmodule

// File: rtl/intr_save_bank.sv
module intr_save_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int PC_W   = 22,
    parameter int VEC_W  = 16,
    parameter int SR_W   = 8,
    parameter int SWI_W  = 6,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_req_n,
    input  logic             norm_req_n,
    input  logic             boundary_i,
    input  logic [PC_W-1:0]  next_pc_i,
    input  logic             soft_i,
    input  logic [SWI_W-1:0] soft_num_i,
    input  logic [1:0]       ret_op_i,
    input  logic [PC_W-1:0]  gr14_i,
    input  logic             sr_we_i,
    input  logic [SR_W-1:0]  sr_wdata_i,
    output logic             vec_rd_o,
    output logic [PC_W-1:0]  vec_addr_o,
    input  logic [VEC_W-1:0] vec_rdata_i,
    output logic             jump_o,
    output logic [PC_W-1:0]  jump_addr_o,
    output logic             gr14_we_o,
    output logic [PC_W-1:0]  gr14_wdata_o,
    output logic             illegal_o,
    output logic             stall_o,
    output logic [SR_W-1:0]  sr_o
);
    localparam int PAD_W  = PC_W - VEC_W;
    localparam int SPAD_W = PC_W - SWI_W - 2;
    localparam int N_REQ  = 2;
    localparam int REQ_FAST = 0;
    localparam int REQ_NORM = 1;

    state_e          state_q, state_d;
    event_e          ev_q, win;
    logic [SR_W-1:0] sr_q;
    logic            fast_pend_q, norm_pend_q;
    logic [N_REQ-1:0] req_pin_n, req_fall;

    logic [PC_W-1:0] fast_pc_q, norm_pc_q;
    logic [SR_W-1:0] fast_sr_q, norm_sr_q, soft_sr_q;

    // ---------------- request synchronizers ----------------
    assign req_pin_n[REQ_FAST] = fast_req_n;
    assign req_pin_n[REQ_NORM] = norm_req_n;

    for (genvar g = 0; g < N_REQ; g++) begin : g_sync
        intr_edge_sync #(.STAGES(SYNC_N)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_n  (req_pin_n[g]),
            .fall_o (req_fall[g])
        );
    end

    // ---------------- boundary decode ----------------
    ret_e ret_kind;
    logic at_bnd, do_ret, soft_legal, take_soft, soft_bad, take_vec;

    assign ret_kind   = ret_e'(ret_op_i);
    assign at_bnd     = (state_q == ST_IDLE) && boundary_i;
    assign do_ret     = at_bnd && (ret_kind != RET_NONE);
    assign soft_legal = (soft_num_i >= SWI_W'(2));

    intr_arbiter u_arb (
        .trace_ok (at_bnd && !do_ret && sr_q[SR_TE]),
        .fast_ok  (at_bnd && !do_ret && fast_pend_q && sr_q[SR_FE]),
        .soft_ok  (at_bnd && !do_ret && soft_i),
        .norm_ok  (at_bnd && !do_ret && norm_pend_q && sr_q[SR_IE]),
        .win_o    (win)
    );

    assign take_soft = (win == EV_SOFT) && soft_legal;
    assign soft_bad  = (win == EV_SOFT) && !soft_legal;
    assign take_vec  = (win == EV_TRACE) || (win == EV_FAST) || (win == EV_NORM);

    // ---------------- save banks ----------------
    intr_save_bank #(.W(PC_W)) u_fast_pc (
        .clk(clk), .rst_n(rst_n), .we(win == EV_FAST), .d(next_pc_i), .q(fast_pc_q));
    intr_save_bank #(.W(SR_W)) u_fast_sr (
        .clk(clk), .rst_n(rst_n), .we(win == EV_FAST), .d(sr_q), .q(fast_sr_q));
    intr_save_bank #(.W(PC_W)) u_norm_pc (
        .clk(clk), .rst_n(rst_n), .we((win == EV_NORM) || (win == EV_TRACE)),
        .d(next_pc_i), .q(norm_pc_q));
    intr_save_bank #(.W(SR_W)) u_norm_sr (
        .clk(clk), .rst_n(rst_n), .we((win == EV_NORM) || (win == EV_TRACE)),
        .d(sr_q), .q(norm_sr_q));
    intr_save_bank #(.W(SR_W)) u_soft_sr (
        .clk(clk), .rst_n(rst_n), .we(take_soft), .d(sr_q), .q(soft_sr_q));

    // ---------------- status register ----------------
    function automatic logic [SR_W-1:0] sr_enter(input logic [SR_W-1:0] s, input event_e ev);
        logic [SR_W-1:0] r;
        r = s;
        r[SR_PM] = 1'b1;
        r[SR_IE] = 1'b0;
        r[SR_TE] = 1'b0;
        if (ev == EV_FAST) r[SR_FE] = 1'b0;
        return r;
    endfunction

    logic [SR_W-1:0] sr_restore;
    always_comb begin
        unique case (ret_kind)
            RET_FAST: sr_restore = fast_sr_q;
            RET_NORM: sr_restore = norm_sr_q;
            RET_SOFT: sr_restore = soft_sr_q;
            default:  sr_restore = sr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SR_W'(1) << SR_PM;
        end else if (do_ret) begin
            sr_q <= sr_restore;
        end else if (take_vec || take_soft) begin
            sr_q <= sr_enter(sr_q, win);
        end else if (sr_we_i) begin
            sr_q <= sr_wdata_i;
        end
    end

    // ---------------- pending requests ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_pend_q <= 1'b0;
            norm_pend_q <= 1'b0;
        end else begin
            fast_pend_q <= (fast_pend_q && (win != EV_FAST)) || req_fall[REQ_FAST];
            norm_pend_q <= (norm_pend_q && (win != EV_NORM)) || req_fall[REQ_NORM];
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            ev_q    <= EV_RESET;
        end else begin
            state_q <= state_d;
            if (take_vec) ev_q <= win;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_FETCH;
            ST_IDLE:  if (take_vec) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        vec_rd_o     = 1'b0;
        vec_addr_o   = '0;
        jump_o       = 1'b0;
        jump_addr_o  = '0;
        gr14_we_o    = 1'b0;
        gr14_wdata_o = '0;
        illegal_o    = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
            end
            ST_FETCH: begin
                vec_rd_o   = 1'b1;
                vec_addr_o = {{(PC_W-4){1'b0}}, vec_off(ev_q)};
            end
            ST_LOAD: begin
                jump_o      = 1'b1;
                jump_addr_o = {{PAD_W{1'b0}}, vec_rdata_i};
            end
            ST_IDLE: begin
                if (do_ret) begin
                    jump_o = 1'b1;
                    unique case (ret_kind)
                        RET_FAST: jump_addr_o = fast_pc_q;
                        RET_NORM: jump_addr_o = norm_pc_q;
                        default:  jump_addr_o = gr14_i;
                    endcase
                end else if (take_soft) begin
                    jump_o       = 1'b1;
                    jump_addr_o  = {{SPAD_W{1'b0}}, soft_num_i, 2'b00};
                    gr14_we_o    = 1'b1;
                    gr14_wdata_o = next_pc_i;
                end else if (soft_bad) begin
                    illegal_o = 1'b1;
                end
            end
        endcase
    end

    assign stall_o = (state_q != ST_IDLE);
    assign sr_o    = sr_q;
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk
    import intr_seq_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int SR_W  = 8,
    parameter int SWI_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_rd_o,
    input logic [PC_W-1:0] vec_addr_o,
    input logic            jump_o,
    input logic [PC_W-1:0] jump_addr_o,
    input logic            gr14_we_o,
    input logic            illegal_o,
    input logic            stall_o,
    input logic            sr_we_i,
    input logic [SR_W-1:0] sr_o
);
    // R1
    vec_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_o |-> (vec_addr_o[PC_W-1:3] == '0) && !vec_addr_o[0]);

    // R3
    fetch_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_o |-> sr_o[SR_PM] && !sr_o[SR_IE] && !sr_o[SR_TE]);

    // R3
    fast_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_o && vec_addr_o == PC_W'(2)) |-> !sr_o[SR_FE]);

    // R6
    soft_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gr14_we_o |-> jump_o && (jump_addr_o[1:0] == 2'b00)
                      && (jump_addr_o[PC_W-1:SWI_W+2] == '0) && (jump_addr_o >= PC_W'(8)));

    // R7
    illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !jump_o && !gr14_we_o);

    // R7
    illegal_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !sr_we_i) |=> $stable(sr_o));

    // R11
    fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_o |=> stall_o && jump_o && !vec_rd_o);

    // R11
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !gr14_we_o && !illegal_o);
endmodule

bind intr_seq intr_seq_chk #(.PC_W(PC_W), .SR_W(SR_W), .SWI_W(SWI_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_rd_o    (vec_rd_o),
    .vec_addr_o  (vec_addr_o),
    .jump_o      (jump_o),
    .jump_addr_o (jump_addr_o),
    .gr14_we_o   (gr14_we_o),
    .illegal_o   (illegal_o),
    .stall_o     (stall_o),
    .sr_we_i     (sr_we_i),
    .sr_o        (sr_o)
);

// File: tb/sim_intr_seq.sv
module sim_intr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_req_n = 1'b1, norm_req_n = 1'b1;
    logic        boundary_i = 1'b0;
    logic [21:0] next_pc_i = '0;
    logic        soft_i = 1'b0;
    logic [5:0]  soft_num_i = '0;
    logic [1:0]  ret_op_i = '0;
    logic [21:0] gr14_i = '0;
    logic        sr_we_i = 1'b0;
    logic [7:0]  sr_wdata_i = '0;
    logic        vec_rd_o, jump_o, gr14_we_o, illegal_o, stall_o;
    logic [21:0] vec_addr_o, jump_addr_o, gr14_wdata_o;
    logic [15:0] vec_rdata_i = '0;
    logic [7:0]  sr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intr_seq u0 (.*);

    function automatic logic [15:0] memf(input logic [21:0] a);
        return 16'h4000 | (16'(a[7:0]) * 16'd37);
    endfunction

    always @(posedge clk) if (vec_rd_o) vec_rdata_i <= memf(vec_addr_o);

    // status after entry: PM set, IE and TE cleared, FE cleared for fast only
    function automatic logic [7:0] sr_in(input logic [7:0] v, input bit fast);
        logic [7:0] r;
        r = (v | 8'h80) & ~8'h05;
        if (fast) r = r & ~8'h02;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_sr(input logic [7:0] v);
        sr_we_i = 1'b1; sr_wdata_i = v;
        tick();
        sr_we_i = 1'b0;
        chk(sr_o == v, "R12 status write", 32'(sr_o), 32'(v));
    endtask

    // called at the negedge when the unit sits in FETCH
    task automatic run_vector(input logic [21:0] loc, input string req);
        chk(vec_rd_o && vec_addr_o == loc, req, 32'(vec_addr_o), 32'(loc));
        boundary_i = 1'b1; soft_i = 1'b1; soft_num_i = 6'd9;
        #1;
        chk(!gr14_we_o && !jump_o, "R11 boundary ignored in fetch", 32'(gr14_we_o), 0);
        tick();
        chk(jump_o && jump_addr_o == {6'h0, memf(loc)}, req,
            32'(jump_addr_o), 32'({6'h0, memf(loc)}));
        tick();
        boundary_i = 1'b0; soft_i = 1'b0;
        chk(!stall_o, "R11 back to idle", 32'(stall_o), 0);
    endtask

    task automatic bnd_event(input logic [21:0] pc);
        boundary_i = 1'b1; next_pc_i = pc;
        tick();
        boundary_i = 1'b0;
    endtask

    task automatic do_ret(input logic [1:0] op, input logic [21:0] g14,
                          input logic [21:0] exp_pc, input logic [7:0] exp_sr);
        ret_op_i = op; gr14_i = g14; boundary_i = 1'b1;
        #1;
        chk(jump_o && jump_addr_o == exp_pc, "R8 return target", 32'(jump_addr_o), 32'(exp_pc));
        tick();
        boundary_i = 1'b0; ret_op_i = 2'd0;
        chk(sr_o == exp_sr, "R8 status restore", 32'(sr_o), 32'(exp_sr));
    endtask

    task automatic pulse_req(input bit fast);
        if (fast) fast_req_n = 1'b0; else norm_req_n = 1'b0;
        repeat (4) tick();
        fast_req_n = 1'b1; norm_req_n = 1'b1;
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [21:0] pc;
        @(negedge clk); tick(); tick();
        // R11 / R1 reset state
        chk(stall_o && !vec_rd_o && !jump_o, "R11 reset stall", 32'(stall_o), 1);
        chk(sr_o == 8'h80, "R1 reset status", 32'(sr_o), 32'h80);
        rst_n = 1'b1;
        tick();
        run_vector(22'h0, "R1 reset vector");
        chk(sr_o == 8'h80, "R1 status after boot", 32'(sr_o), 32'h80);

        // R6 / R7 software interrupt sweep over all numbers
        for (int n = 0; n < 64; n++) begin
            v  = 8'h83 | 8'((n & 3) << 4);
            pc = 22'h1000 + 22'(n);
            wr_sr(v);
            boundary_i = 1'b1; soft_i = 1'b1; soft_num_i = 6'(n); next_pc_i = pc;
            #1;
            if (n < 2) begin
                chk(illegal_o && !jump_o && !gr14_we_o, "R7 prohibited number",
                    32'({illegal_o, jump_o, gr14_we_o}), 32'b100);
                tick();
                boundary_i = 1'b0; soft_i = 1'b0;
                chk(sr_o == v, "R7 status kept", 32'(sr_o), 32'(v));
            end else begin
                chk(jump_o && jump_addr_o == 22'(n * 4), "R6 target", 32'(jump_addr_o), 32'(n * 4));
                chk(gr14_we_o && gr14_wdata_o == pc, "R6 r14 save", 32'(gr14_wdata_o), 32'(pc));
                tick();
                boundary_i = 1'b0; soft_i = 1'b0;
                chk(sr_o == sr_in(v, 1'b0), "R6 status", 32'(sr_o), 32'(sr_in(v, 1'b0)));
                do_ret(2'd3, pc, pc, v);
            end
        end

        // R3 fast request sweep
        for (int k = 0; k < 16; k++) begin
            v  = 8'h02 | (k[0] ? 8'h01 : 8'h00) | 8'((k >> 1) << 4);
            pc = 22'h2A000 + 22'(k);
            wr_sr(v);
            pulse_req(1'b1);
            bnd_event(pc);
            run_vector(22'h2, "R3 fast vector");
            chk(sr_o == sr_in(v, 1'b1), "R3 fast status", 32'(sr_o), 32'(sr_in(v, 1'b1)));
            do_ret(2'd1, '0, pc, v);
        end

        // R4 normal request sweep
        for (int k = 0; k < 16; k++) begin
            v  = 8'h01 | (k[0] ? 8'h02 : 8'h00) | 8'((k >> 1) << 4);
            pc = 22'h3F000 + 22'(k);
            wr_sr(v);
            pulse_req(1'b0);
            bnd_event(pc);
            run_vector(22'h4, "R4 normal vector");
            chk(sr_o == sr_in(v, 1'b0), "R4 normal status", 32'(sr_o), 32'(sr_in(v, 1'b0)));
            do_ret(2'd2, '0, pc, v);
        end

        // R5 trace on every boundary, normal bank reused
        wr_sr(8'h07);
        bnd_event(22'h12345);
        run_vector(22'h6, "R5 trace vector");
        chk(sr_o == 8'h82, "R5 trace status", 32'(sr_o), 32'h82);
        do_ret(2'd2, '0, 22'h12345, 8'h07);
        bnd_event(22'h12346);
        run_vector(22'h6, "R5 second trace");
        wr_sr(8'h80);

        // R9 enable gating and pending retention
        pulse_req(1'b0);
        boundary_i = 1'b1; next_pc_i = 22'h500;
        #1;
        chk(!jump_o, "R9 normal masked", 32'(jump_o), 0);
        tick();
        boundary_i = 1'b0;
        chk(!stall_o, "R9 normal masked no fetch", 32'(stall_o), 0);
        wr_sr(8'h81);
        bnd_event(22'h501);
        run_vector(22'h4, "R9 pending normal taken");
        do_ret(2'd2, '0, 22'h501, 8'h81);
        bnd_event(22'h502);
        chk(!stall_o, "R10 edge taken once", 32'(stall_o), 0);
        wr_sr(8'h80);

        // R2 priority
        fast_req_n = 1'b0; norm_req_n = 1'b0;
        repeat (4) tick();
        fast_req_n = 1'b1; norm_req_n = 1'b1;
        repeat (4) tick();
        wr_sr(8'h87);
        boundary_i = 1'b1; soft_i = 1'b1; soft_num_i = 6'd5; next_pc_i = 22'h700;
        #1;
        chk(!gr14_we_o, "R2 trace over soft", 32'(gr14_we_o), 0);
        tick();
        boundary_i = 1'b0; soft_i = 1'b0;
        run_vector(22'h6, "R2 trace first");
        wr_sr(8'h83);
        boundary_i = 1'b1; soft_i = 1'b1; soft_num_i = 6'd5;
        #1;
        chk(!gr14_we_o, "R2 fast over soft", 32'(gr14_we_o), 0);
        tick();
        boundary_i = 1'b0; soft_i = 1'b0;
        run_vector(22'h2, "R2 fast second");
        wr_sr(8'h83);
        boundary_i = 1'b1; soft_i = 1'b1; soft_num_i = 6'd5;
        #1;
        chk(gr14_we_o && jump_addr_o == 22'd20, "R2 soft over normal", 32'(jump_addr_o), 20);
        tick();
        boundary_i = 1'b0; soft_i = 1'b0;
        chk(!stall_o, "R2 soft no fetch", 32'(stall_o), 0);
        wr_sr(8'h83);
        bnd_event(22'h701);
        run_vector(22'h4, "R2 normal last");
        wr_sr(8'h82);

        // R10 synchronizer latency and level insensitivity
        fast_req_n = 1'b0; boundary_i = 1'b1; next_pc_i = 22'h900;
        for (int c = 0; c < 3; c++) begin
            tick();
            chk(!stall_o, "R10 not yet taken", 32'(stall_o), 0);
        end
        tick();
        boundary_i = 1'b0;
        chk(stall_o, "R10 taken at fourth edge", 32'(stall_o), 1);
        run_vector(22'h2, "R10 fast vector");
        wr_sr(8'h82);
        bnd_event(22'h901);
        chk(!stall_o, "R10 low level no retrigger", 32'(stall_o), 0);
        fast_req_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule